// File: doc/BRIEF.md
# Programmable Down-Count Timer with Interrupt Entry

The block is a local countdown timer whose expiry behaviour is set by one 32-bit control word, the timer entry. Software writes the entry, a divider code and an initial count through a write port that has a valid, an address and a data bus. A write of the initial count loads the counter and starts it. The counter then steps down once per divider tick. When it passes from one to zero the block reads the entry. If the entry is not masked, the block sends out a single interrupt request that carries the vector, delivery mode and trigger flag taken from the entry.

The periodic bit of the entry decides what follows an expiry. In periodic mode the counter reloads from the stored initial count. This happens whether or not the request was masked. In one-shot mode the counter stays at zero until software writes a new initial count. The entry and the live count are always visible on plain outputs. The write port has no ready signal: every write is taken in the cycle it is presented, so it never applies back-pressure. The request is a one-cycle pulse and has no ready either. A consumer must capture it in the cycle it appears.

Top module: `tick_vector_timer`

## Requirements
- R1: After reset the entry reads 0x0001_0000 (only the mask bit 16 set), the current count is 0 and no request is asserted.
- R2: A write with address 0 stores the entry, keeping bits 7:0 (vector), 10:8 (mode), 12 to 15 and bits 16 (mask) and 17 (periodic); bit 11 and bits 31:18 always read back as zero.
- R3: A write with address 1 stores the initial count and loads it into the counter in the same edge; the counter then decreases by exactly one per divider tick and its value is shown on `cur_count`.
- R4: A write with address 2 sets the divider code from data bits 2:0; code d gives one tick every 2^d clocks, with the phase restarted by each initial-count write, so a count of N expires N*2^d clocks after its write.
- R5: When the counter steps from 1 to 0 and entry bit 16 is clear, `irq_valid` is high for exactly one cycle, the cycle after that edge, with `irq_vector`, `irq_mode` and `irq_level` equal to entry bits 7:0, 10:8 and 15.
- R6: When entry bit 16 is set at expiry, no request is issued.
- R7: With entry bit 17 set, the counter reloads from the initial count on expiry, whether or not the entry is masked.
- R8: With entry bit 17 clear, the counter stays at zero after expiry and issues no further request until the initial count is written again.
- R9: Writing an initial count of zero stops the counter at zero without issuing a request.
- R10: An initial-count write in the same cycle as an expiring tick wins: the new count is loaded and no request is issued for that expiry.
- R11: Entry bits 12, 13 and 14 are stored and read back but change neither counting nor any request field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Write strobe, taken in the cycle it is high |
| cfg_addr | input | 2 | 0 entry, 1 initial count, 2 divider code, 3 ignored |
| cfg_wdata | input | 32 | Write data |
| irq_valid | output | 1 | One-cycle interrupt request pulse |
| irq_vector | output | 8 | Vector of the request |
| irq_mode | output | 3 | Delivery mode of the request |
| irq_level | output | 1 | Trigger flag of the request, 1 means level |
| entry_q | output | 32 | Stored entry, read-only view |
| cur_count | output | CNT_W | Current counter value |

## Verification
The bench aims at the expiry edge. A count of one with divider code zero expires on the first edge after the write, and a design that is off by one there either misses the request or sends it a tick late. It writes a new initial count in exactly the cycle of an expiring tick; a design that gives the expiry priority would send a stray request or lose the load. Masked periodic runs catch a design that couples the reload to the mask and so freezes the counter. One-shot runs catch a design that wraps below zero and fires again. Entries with the status, polarity and remote bits toggled catch request fields read from the wrong positions.

// File: rtl/tvt_pkg.sv
package tvt_pkg;
  localparam int ENTRY_W  = 32;
  localparam int VEC_W    = 8;
  localparam int MODE_W   = 3;
  localparam int VEC_LSB  = 0;
  localparam int MODE_LSB = 8;
  localparam int LVL_BIT  = 15;
  localparam int MASK_BIT = 16;
  localparam int PER_BIT  = 17;
  // writable bits of the entry: 17:12 and 10:0
  localparam logic [ENTRY_W-1:0] ENTRY_KEEP = 32'h0003_F7FF;
  localparam logic [ENTRY_W-1:0] ENTRY_RST  = 32'h0001_0000;

  typedef enum logic [1:0] {
    A_ENTRY = 2'd0,
    A_INIT  = 2'd1,
    A_DIV   = 2'd2,
    A_NONE  = 2'd3
  } cfg_addr_e;
endpackage

// File: rtl/tvt_prescale.sv
module tvt_prescale #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_code,
  output logic             tick
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] low_mask;

  always_comb begin
    low_mask = '0;
    for (int i = 0; i < PRE_W; i++) begin
      low_mask[i] = (i < int'(div_code));
    end
    tick = ((pre_q & low_mask) == low_mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) pre_q <= '0;
    else                   pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tvt_entry_reg.sv
module tvt_entry_reg
  import tvt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ENTRY_W-1:0] wdata,
  output logic [ENTRY_W-1:0] entry_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     entry_q <= ENTRY_RST;
    else if (wr_en) entry_q <= wdata & ENTRY_KEEP;
  end
endmodule

// File: rtl/tvt_counter.sv
module tvt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             periodic,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // a load in the same cycle suppresses the expiry
  assign expire = tick && (count == ONE) && !load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (tick && count != '0) begin
      if (count == ONE) count <= periodic ? reload_val : '0;
      else              count <= count - ONE;
    end
  end
endmodule

// File: rtl/tick_vector_timer.sv
module tick_vector_timer
  import tvt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_valid,
  input  logic [1:0]             cfg_addr,
  input  logic [ENTRY_W-1:0]     cfg_wdata,
  output logic                   irq_valid,
  output logic [VEC_W-1:0]       irq_vector,
  output logic [MODE_W-1:0]      irq_mode,
  output logic                   irq_level,
  output logic [ENTRY_W-1:0]     entry_q,
  output logic [CNT_W-1:0]       cur_count
);
  logic             wr_entry, wr_init, wr_div;
  logic [CNT_W-1:0] init_q;
  logic [DIV_W-1:0] div_q;
  logic             tick, expire;

  assign wr_entry = cfg_valid && (cfg_addr == A_ENTRY);
  assign wr_init  = cfg_valid && (cfg_addr == A_INIT);
  assign wr_div   = cfg_valid && (cfg_addr == A_DIV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q <= '0;
      div_q  <= '0;
    end else begin
      if (wr_init) init_q <= cfg_wdata[CNT_W-1:0];
      if (wr_div)  div_q  <= cfg_wdata[DIV_W-1:0];
    end
  end

  tvt_entry_reg u_entry (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_entry),
    .wdata   (cfg_wdata),
    .entry_q (entry_q)
  );

  tvt_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (wr_init),
    .div_code (div_q),
    .tick     (tick)
  );

  tvt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (wr_init),
    .load_val   (cfg_wdata[CNT_W-1:0]),
    .tick       (tick),
    .periodic   (entry_q[PER_BIT]),
    .reload_val (init_q),
    .count      (cur_count),
    .expire     (expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
      irq_mode   <= '0;
      irq_level  <= 1'b0;
    end else begin
      irq_valid <= expire && !entry_q[MASK_BIT];
      if (expire) begin
        irq_vector <= entry_q[VEC_LSB +: VEC_W];
        irq_mode   <= entry_q[MODE_LSB +: MODE_W];
        irq_level  <= entry_q[LVL_BIT];
      end
    end
  end
endmodule

// File: rtl/tvt_checker.sv
module tvt_checker
  import tvt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_valid,
  input logic [1:0]         cfg_addr,
  input logic               irq_valid,
  input logic [VEC_W-1:0]   irq_vector,
  input logic [ENTRY_W-1:0] entry_q,
  input logic [CNT_W-1:0]   cur_count
);
  logic init_wr;
  assign init_wr = cfg_valid && (cfg_addr == A_INIT);

  // R5: a request only follows a step out of count one
  p_from_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ($past(cur_count) == CNT_W'(1)));

  // R5: request vector equals the entry vector at the expiry edge
  p_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector == $past(entry_q[VEC_LSB +: VEC_W])));

  // R6: masked entry never yields a request
  p_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(entry_q[MASK_BIT]));

  // R8: idle counter stays idle without an initial-count write
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_count == '0 && !init_wr) |=> (cur_count == '0));

  // R3: above one, the counter holds or steps down by one
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_count > CNT_W'(1) && !init_wr) |=>
      (cur_count == $past(cur_count) || cur_count == $past(cur_count) - CNT_W'(1)));
endmodule

bind tick_vector_timer tvt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_valid  (cfg_valid),
  .cfg_addr   (cfg_addr),
  .irq_valid  (irq_valid),
  .irq_vector (irq_vector),
  .entry_q    (entry_q),
  .cur_count  (cur_count)
);

// File: tb/sim_tick_vector_timer.sv
`timescale 1ns/1ps
module sim_tick_vector_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        irq_valid;
  logic [7:0]  irq_vector;
  logic [2:0]  irq_mode;
  logic        irq_level;
  logic [31:0] entry_q;
  logic [31:0] cur_count;

  int n_chk = 0;
  int n_fail = 0;
  int n_pulse = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] m_entry, m_init, m_cnt;
  logic [2:0]  m_div;
  logic [6:0]  m_pre;
  logic        m_irq, m_lvl;
  logic [7:0]  m_vec;
  logic [2:0]  m_mode;

  always #5 clk = ~clk;

  tick_vector_timer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .irq_valid(irq_valid), .irq_vector(irq_vector),
    .irq_mode(irq_mode), .irq_level(irq_level), .entry_q(entry_q),
    .cur_count(cur_count)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] div_mask(input logic [2:0] d);
    return 7'((8'd1 << d) - 8'd1);
  endfunction

  // advance model and design by one clock, then compare at the falling edge
  task automatic step(input string tag);
    logic wi, tk, ex;
    wi = cfg_valid && cfg_addr == 2'd1;
    tk = ((m_pre & div_mask(m_div)) == div_mask(m_div));
    ex = tk && m_cnt == 32'd1 && !wi;
    m_irq = ex && !m_entry[16];
    if (ex) begin m_vec = m_entry[7:0]; m_mode = m_entry[10:8]; m_lvl = m_entry[15]; end
    if (wi) m_cnt = cfg_wdata;
    else if (tk && m_cnt != 0) m_cnt = (m_cnt == 1) ? (m_entry[17] ? m_init : 32'd0) : m_cnt - 1;
    m_pre = wi ? 7'd0 : m_pre + 7'd1;
    if (cfg_valid && cfg_addr == 2'd0) m_entry = cfg_wdata & 32'h0003_F7FF;
    if (wi) m_init = cfg_wdata;
    if (cfg_valid && cfg_addr == 2'd2) m_div = cfg_wdata[2:0];
    @(posedge clk);
    @(negedge clk);
    if (irq_valid) n_pulse++;
    chk({tag, " irq_valid"}, {31'd0, irq_valid}, {31'd0, m_irq});
    if (m_irq) chk({tag, " irq fields"}, {20'd0, irq_level, irq_mode, irq_vector},
                   {20'd0, m_lvl, m_mode, m_vec});
    chk({tag, " count"}, cur_count, m_cnt);
    chk({tag, " entry"}, entry_q, m_entry);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
    cfg_valid = 1'b1; cfg_addr = a; cfg_wdata = d;
    step(tag);
    cfg_valid = 1'b0; cfg_addr = 2'd3; cfg_wdata = '0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int p0;
    void'($urandom(32'd7321));
    m_entry = 32'h0001_0000; m_init = 0; m_cnt = 0; m_div = 0; m_pre = 0;
    m_irq = 0; m_vec = 0; m_mode = 0; m_lvl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 entry", entry_q, 32'h0001_0000);
    chk("R1 count", cur_count, 32'd0);
    chk("R1 irq", {31'd0, irq_valid}, 32'd0);
    idle(2, "R1");

    // R2 reserved bits read zero
    wr(2'd0, 32'hFFFF_FFFF, "R2");
    chk("R2 readback", entry_q, 32'h0003_F7FF);

    // R5 / R3 / R8 one-shot unmasked, vector 0x41 mode 3 level
    wr(2'd0, 32'h0000_8341, "R5");
    p0 = n_pulse;
    wr(2'd1, 32'd5, "R3");
    idle(10, "R8");
    chk("R5 one pulse", n_pulse - p0, 1);

    // R6 / R7 masked periodic keeps reloading, never requests
    wr(2'd0, 32'h0003_0022, "R6");
    p0 = n_pulse;
    wr(2'd1, 32'd3, "R7");
    idle(12, "R7");
    chk("R6 no pulse", n_pulse - p0, 0);

    // R4 divider 4, periodic unmasked count 2 -> pulse every 8 clocks
    wr(2'd2, 32'd2, "R4");
    wr(2'd0, 32'h0002_0590, "R4");
    p0 = n_pulse;
    wr(2'd1, 32'd2, "R4");
    idle(24, "R4");
    chk("R4 pulses in 24", n_pulse - p0, 3);

    // R9 zero write stops
    wr(2'd1, 32'd0, "R9");
    p0 = n_pulse;
    idle(20, "R9");
    chk("R9 stopped", cur_count, 32'd0);
    chk("R9 no pulse", n_pulse - p0, 0);

    // R10 load collides with expiring tick
    wr(2'd2, 32'd0, "R10");
    wr(2'd0, 32'h0000_0077, "R10");
    wr(2'd1, 32'd1, "R10");
    p0 = n_pulse;
    wr(2'd1, 32'd4, "R10");
    chk("R10 no pulse", n_pulse - p0, 0);
    chk("R10 loaded", cur_count, 32'd4);
    idle(6, "R10");

    // R11 status/polarity/remote bits have no effect
    wr(2'd0, 32'h0000_72AB, "R11");
    wr(2'd1, 32'd2, "R11");
    idle(4, "R11");
    chk("R11 fields", {20'd0, irq_level, irq_mode, irq_vector}, {20'd0, 1'b0, 3'd2, 8'hAB});

    // random mix
    for (int k = 0; k < 3000; k++) begin
      if (($urandom % 6) == 0) begin
        int a;
        a = $urandom % 4;
        case (a)
          0: wr(2'd0, $urandom, "R3 random");
          1: wr(2'd1, $urandom % 12, "R3 random");
          2: wr(2'd2, $urandom % 3, "R4 random");
          default: wr(2'd3, $urandom, "R2 random");
        endcase
      end else begin
        step("R5 random");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule